// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block turns a framed serial bit stream into 12-bit parallel words. It runs on the bit clock that arrives with the data, so every rising edge of `clk` samples one bit of `din`. A frame is one start bit (1), twelve data bits sent most significant bit first, and one stop bit (0). Any number of zero bits may sit between frames. These idle and padding bits produce no output.

For every good frame the block updates `dout` and drives the word clock `wclk` low for exactly 13 bit times. `wclk` then returns high and stays high until the next good word. When frames are spaced 14, 14 and 16 bit times apart, the `wclk` period follows that spacing. A frame whose stop bit reads 1 is dropped and flagged. After reset, and after each re-enable, the block waits for 14 zero bits in a row before it hunts for a start bit. Pulling `en` low powers the receiver down and forces every parallel output low.

Top module: `framed_word_rx`

## Requirements
- R1: After reset or re-enable, no frame is accepted until 14 consecutive zero bits have been sampled. A one bit seen earlier restarts that count, so 13 zeros followed by a start bit are not enough.
- R2: A frame is start bit 1, then 12 data bits with the MSB first, then stop bit 0. On the edge that samples a 0 stop bit, `dout` takes the 12 data bits and `wclk` goes low.
- R3: After each accepted word, `wclk` stays low for exactly 13 bit clocks and then goes high.
- R4: Zero bits between frames are ignored, whatever their number. They cause no `wclk` fall and no change to `dout`.
- R5: A frame whose stop bit is 1 is discarded. On the stop edge `ferr` pulses high for one cycle, and `dout` and `wclk` do not change. The receiver goes back to hunting, so a frame that follows at once is accepted.
- R6: `dout` changes only together with a falling edge of `wclk`. It holds its value through the rest of the word period.
- R7: While `en` is 0, `dout`, `wclk`, `oe` and `ferr` are all 0. Re-enabling requires a new run of 14 zero bits, as in R1.
- R8: After reset with `en` at 1, `dout` is 0, `wclk` is 1, `ferr` is 0 and `oe` is 1.
- R9: The `wclk` period equals the spacing between accepted frames. With frames spaced 14, 14 and 16 bits apart, the periods are 14, 14 and 16 bit clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock that travels with the serial data |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Receiver enable; 0 selects power-down |
| din | input | 1 | Serial data, sampled on the rising edge of `clk` |
| dout | output | 12 | Last accepted word |
| wclk | output | 1 | Regenerated word clock; falls once per accepted word |
| oe | output | 1 | Parallel output enable; high while the receiver is enabled |
| ferr | output | 1 | One-cycle pulse when a frame has a 1 stop bit |

## Verification
The assertions assume that `din` changes only between rising edges of the bit clock. They also assume that accepted frames are at least 14 bit times apart, which the frame length guarantees because the start bit can come no earlier than the bit after the previous stop bit. The bench drives `din` and `en` only on falling edges. It builds every frame from a start bit, twelve data bits and a chosen stop bit, and varies the number of zero bits between frames. It sweeps all 4096 data values with gaps that produce the 14/14/16 cadence along with some longer idle runs.

// File: rtl/framed_word_rx.sv
module framed_word_rx #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] dout,
  output logic         wclk,
  output logic         oe,
  output logic         ferr
);
  localparam int LOW  = W + 1;
  localparam int SYNC = W + 2;
  localparam int CW   = $clog2(SYNC + 1);
  localparam int LW   = $clog2(LOW + 1);

  typedef enum logic [1:0] {S_SYNC, S_HUNT, S_DATA, S_STOP} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [LW-1:0] lowcnt;
  logic [W-1:0]  sh, data_q;
  logic          wclk_q, ferr_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st     <= S_SYNC;
      cnt    <= '0;
      sh     <= '0;
      data_q <= '0;
      wclk_q <= 1'b1;
      lowcnt <= '0;
      ferr_q <= 1'b0;
    end else begin
      ferr_q <= 1'b0;
      if (!wclk_q) begin
        if (lowcnt == LW'(LOW - 1)) wclk_q <= 1'b1;
        else lowcnt <= lowcnt + 1'b1;
      end
      case (st)
        S_SYNC:
          if (din) cnt <= '0;
          else if (cnt == CW'(SYNC - 1)) begin st <= S_HUNT; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_HUNT:
          if (din) begin st <= S_DATA; cnt <= '0; end
        S_DATA: begin
          sh <= {sh[W-2:0], din};
          if (cnt == CW'(W - 1)) st <= S_STOP;
          else cnt <= cnt + 1'b1;
        end
        S_STOP: begin
          st  <= S_HUNT;
          cnt <= '0;
          if (!din) begin
            data_q <= sh;
            wclk_q <= 1'b0;
            lowcnt <= '0;
          end else ferr_q <= 1'b1;
        end
        default: st <= S_SYNC;
      endcase
    end
  end

  assign dout = en ? data_q : '0;
  assign wclk = en & wclk_q;
  assign ferr = en & ferr_q;
  assign oe   = en;

  p_sync_r1: assert property (@(posedge clk) disable iff (rst)
    (st == S_HUNT && $past(st) == S_SYNC) |-> ($past(cnt) == CW'(SYNC - 1) && !$past(din)));

  p_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(wclk_q) |-> ($past(st) == S_STOP && !$past(din)));

  p_low_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(wclk_q) && $past(en)) |-> $past(lowcnt) == LW'(LOW - 1));

  p_err_r5: assert property (@(posedge clk) disable iff (rst)
    ferr_q |-> (wclk_q && $stable(data_q)));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$fell(wclk_q)) |-> $stable(data_q));

  p_off_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (data_q == '0 && st == S_SYNC && wclk_q));
endmodule

// File: tb/sim_framed_word_rx.sv
`timescale 1ns/1ps
module sim_framed_word_rx;
  logic clk = 0, rst = 1, en = 1, din = 0;
  logic [11:0] dout;
  logic wclk, oe, ferr;
  int checks = 0, errors = 0;
  bit mon_on = 0, mon_init = 1, done = 0;
  int cyc = 0, falls = 0, last_period = 0, fall_cyc = 0, lowlen = 0;
  logic pw;
  logic [11:0] pd;

  always #2.5 clk = ~clk;

  framed_word_rx u0 (.clk(clk), .rst(rst), .en(en), .din(din),
                     .dout(dout), .wclk(wclk), .oe(oe), .ferr(ferr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    if (!mon_on) mon_init = 1;
    else if (mon_init) begin
      pw = wclk; pd = dout; lowlen = 0; mon_init = 0;
    end else begin
      if (wclk && !pw) chk(lowlen == 13, "R3 low length", lowlen, 13);
      if (!wclk && pw) begin
        falls++;
        last_period = cyc - fall_cyc;
        fall_cyc = cyc;
        lowlen = 1;
      end else if (!wclk) lowlen++;
      if (dout != pd && !(pw && !wclk)) chk(0, "R6 dout moved without wclk fall", dout, pd);
      pw = wclk; pd = dout;
    end
  end

  task automatic send_bit(input bit b);
    din = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [11:0] w, input bit stopb, input int gap,
                            input int exp_per, input bit exp_ok);
    repeat (gap) send_bit(1'b0);
    send_bit(1'b1);
    for (int i = 11; i >= 0; i--) send_bit(w[i]);
    send_bit(stopb);
    if (exp_ok) begin
      chk(dout == w, "R2 dout", dout, w);
      chk(wclk == 1'b0, "R2 wclk fell", wclk, 0);
      if (exp_per > 0) chk(last_period == exp_per, "R9 period", last_period, exp_per);
    end
  endtask

  initial begin
    int f0;
    logic [11:0] last;
    repeat (4) @(negedge clk);
    chk(dout == 0, "R8 dout", dout, 0);
    chk(wclk == 1, "R8 wclk", wclk, 1);
    chk(oe == 1, "R8 oe", oe, 1);
    chk(ferr == 0, "R8 ferr", ferr, 0);
    rst = 0;
    mon_on = 1;
    f0 = falls;
    send_frame(12'h5A5, 0, 3, 0, 0);
    chk(falls == f0 && dout == 0, "R1 early frame ignored", dout, 0);
    send_frame(12'h5A5, 0, 12, 0, 0);
    chk(falls == f0 && dout == 0, "R1 13 zeros not enough", dout, 0);
    send_frame(12'h9C3, 0, 13, 0, 1);
    last = 12'h9C3;
    for (int w = 0; w < 4096; w++) begin
      int g;
      g = (w % 3 == 2) ? 2 : ((w % 17 == 0) ? 5 : 0);
      send_frame(w[11:0], 0, g, 14 + g, 1);
      last = w[11:0];
    end
    repeat (14) send_bit(0);
    send_frame(12'h3C3, 1, 0, 0, 0);
    chk(ferr == 1, "R5 ferr pulse", ferr, 1);
    chk(dout == last, "R5 dout kept", dout, last);
    chk(wclk == 1, "R5 no wclk fall", wclk, 1);
    send_bit(0);
    chk(ferr == 0, "R5 ferr one cycle", ferr, 0);
    send_frame(12'h0F0, 0, 0, 0, 1);
    f0 = falls;
    repeat (20) send_bit(0);
    chk(falls == f0 && dout == 12'h0F0, "R4 idle zeros ignored", dout, 12'h0F0);
    send_frame(12'h001, 0, 40, 74, 1);
    mon_on = 0;
    en = 0;
    @(negedge clk);
    chk(dout == 0, "R7 dout off", dout, 0);
    chk(wclk == 0, "R7 wclk off", wclk, 0);
    chk(oe == 0, "R7 oe off", oe, 0);
    chk(ferr == 0, "R7 ferr off", ferr, 0);
    send_bit(1);
    chk(dout == 0 && wclk == 0, "R7 stays off", dout, 0);
    en = 1;
    @(negedge clk);
    mon_on = 1;
    send_frame(12'hA5A, 0, 0, 0, 0);
    chk(dout == 0 && wclk == 1, "R7 resync required", dout, 0);
    send_frame(12'h777, 0, 14, 0, 1);
    repeat (16) send_bit(0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule